// File: doc/BRIEF.md
# DRAM Bank Timing Tracker

This block sits in front of a DRAM command scheduler and keeps, for each of eight banks, whether a row is open, which row it is, and how many cycles remain before each activation-related minimum is met. The scheduler presents one candidate command per cycle: an operation code, a bank, a row and a speed-grade select. In the same cycle the block answers with exactly one of three verdicts: legal, stall or illegal.

A stall means the command is allowed by the bank's open/closed state but a timing window is still running. An illegal command breaks the bank's state rules. Only a legal command changes the tracked state. That change is taken at the clock edge that ends the cycle in which the command was presented.

The minimum delays are fixed in nanoseconds. Activate-to-column and precharge-to-activate are 15 ns for every grade. Activate-to-activate on one bank is 55 ns at the slowest grade and 60 ns at the others. Each minimum is turned into a whole number of clock cycles for the selected grade through a small lookup that is computed when the design is elaborated.

Top module: `bank_timing_tracker`

## Requirements
- R1: After reset every bank is closed, every open-row field reads 0, a READ to any bank is illegal and an ACTIVATE to any bank is legal.
- R2: A legal ACTIVATE (cmd_i = 0) opens its bank. From the next cycle, bank_open_o[bank] is 1 and open_row_o[bank*14 +: 14] holds the row given with the command.
- R3: A READ (cmd_i = 1) or WRITE (cmd_i = 2) to a closed bank raises cmd_illegal_o and changes no bank state.
- R4: An ACTIVATE to an open bank raises cmd_illegal_o and leaves that bank's stored row unchanged.
- R5: A READ or WRITE to an open bank stalls until it is presented at least tRCD cycles after the cycle of its ACTIVATE. At exactly tRCD cycles it is legal.
- R6: An ACTIVATE stalls until it is presented at least tRP cycles after the cycle of a legal PRECHARGE (cmd_i = 3) to an open bank.
- R7: An ACTIVATE stalls until it is presented at least tRC cycles after the cycle of the previous ACTIVATE to the same bank.
- R8: Cycle counts are ceil(ns × MHz / 1000), using grade_i 0/1/2/3 = 200/267/333/400 MHz. This gives tRCD = tRP = 3/5/5/6 and tRC = 11/17/20/24.
- R9: Banks are independent. A running window on one bank does not stall commands to another bank.
- R10: A PRECHARGE to a closed bank is legal, has no effect and does not start a tRP window.
- R11: A stalled command changes no state. In particular, a stalled ACTIVATE does not open its bank.
- R12: While cmd_valid_i is 0, all three verdict outputs are 0 and no state changes. While it is 1, exactly one verdict is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | A candidate command is presented this cycle |
| cmd_i | input | 2 | 0 ACTIVATE, 1 READ, 2 WRITE, 3 PRECHARGE |
| bank_i | input | 3 | Target bank |
| row_i | input | 14 | Row address, used by ACTIVATE |
| grade_i | input | 2 | Speed grade: 0..3 = 200, 267, 333, 400 MHz |
| cmd_legal_o | output | 1 | Command may issue now and is accepted |
| cmd_stall_o | output | 1 | Command is state-correct but a window is still running |
| cmd_illegal_o | output | 1 | Command violates the bank's open/closed state |
| bank_open_o | output | 8 | One bit per bank, 1 when a row is open |
| open_row_o | output | 112 | Open row of bank b at bits b*14 +: 14 |

## Verification
The verdict outputs are combinational and answer in the same cycle the command is presented. Bank state and open rows change at the next edge and are read one cycle later. A window of N cycles makes a command presented N cycles after its trigger the first one that is legal. The bench drives each command just after a falling edge and samples one time unit later, before the rising edge that would accept it. It measures each window by presenting the dependent command every cycle and recording the first cycle whose verdict is legal.

// File: rtl/bank_timing_pkg.sv
package bank_timing_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  localparam int NUM_GRADES = 4;
  localparam int RCD_NS     = 15;
  localparam int RP_NS      = 15;

  function automatic int grade_mhz(int g);
    case (g)
      0:       return 200;
      1:       return 267;
      2:       return 333;
      default: return 400;
    endcase
  endfunction

  function automatic int grade_rc_ns(int g);
    return (g == 0) ? 55 : 60;
  endfunction

  // round up to whole cycles
  function automatic int ns_to_cyc(int ns, int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  localparam int MAX_CYC = ns_to_cyc(60, 400);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

endpackage

// File: rtl/grade_lut.sv
module grade_lut
  import bank_timing_pkg::*;
#(
  parameter int GRADES = NUM_GRADES,
  localparam int GW    = $clog2(GRADES)
) (
  input  logic [GW-1:0]    grade_i,
  output logic [CNT_W-1:0] trcd_o,
  output logic [CNT_W-1:0] trp_o,
  output logic [CNT_W-1:0] trc_o
);

  logic [CNT_W-1:0] rcd_tab [GRADES];
  logic [CNT_W-1:0] rp_tab  [GRADES];
  logic [CNT_W-1:0] rc_tab  [GRADES];

  for (genvar g = 0; g < GRADES; g++) begin : g_tab
    assign rcd_tab[g] = CNT_W'(ns_to_cyc(RCD_NS, grade_mhz(g)));
    assign rp_tab[g]  = CNT_W'(ns_to_cyc(RP_NS, grade_mhz(g)));
    assign rc_tab[g]  = CNT_W'(ns_to_cyc(grade_rc_ns(g), grade_mhz(g)));
  end

  assign trcd_o = rcd_tab[grade_i];
  assign trp_o  = rp_tab[grade_i];
  assign trc_o  = rc_tab[grade_i];

  // R8: a row cycle always spans more than a precharge window
  always_comb begin
    a_r8_rc_covers_rp : assert (trc_o > trp_o);
  end

endmodule

// File: rtl/bank_timer.sv
module bank_timer
  import bank_timing_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [CNT_W-1:0] trcd_i,
  input  logic [CNT_W-1:0] trp_i,
  input  logic [CNT_W-1:0] trc_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rcd_ok_o,
  output logic             rp_ok_o,
  output logic             rc_ok_o
);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] rcd_q, rp_q, rc_q;
  logic             close_now;

  assign close_now = pre_i && open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (close_now) begin
      open_q <= 1'b0;
    end
  end

  // windows count down to zero; load N-1 so cycle N after the trigger is clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcd_q <= '0;
      rc_q  <= '0;
    end else if (act_i) begin
      rcd_q <= trcd_i - 1'b1;
      rc_q  <= trc_i - 1'b1;
    end else begin
      rcd_q <= (rcd_q != '0) ? rcd_q - 1'b1 : '0;
      rc_q  <= (rc_q  != '0) ? rc_q  - 1'b1 : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rp_q <= '0;
    else if (close_now) rp_q <= trp_i - 1'b1;
    else                rp_q <= (rp_q != '0) ? rp_q - 1'b1 : '0;
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign rcd_ok_o = (rcd_q == '0);
  assign rp_ok_o  = (rp_q == '0);
  assign rc_ok_o  = (rc_q == '0);

  a_r2_act_opens_row : assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> open_o && row_o == $past(row_i));
  a_r4_act_only_closed : assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_q);
  a_r7_act_after_windows : assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> rp_ok_o && rc_ok_o);
  a_r5_rcd_starts : assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> !rcd_ok_o && !rc_ok_o);
  a_r6_rp_starts : assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_now |=> !rp_ok_o && !open_o);
  a_r10_pre_closed_quiet : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && !open_q && rp_ok_o) |=> rp_ok_o && !open_o);

endmodule

// File: rtl/cmd_judge.sv
module cmd_judge
  import bank_timing_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] cmd_i,
  input  logic       open_i,
  input  logic       rcd_ok_i,
  input  logic       rp_ok_i,
  input  logic       rc_ok_i,
  output logic       legal_o,
  output logic       stall_o,
  output logic       illegal_o
);

  always_comb begin
    legal_o   = 1'b0;
    stall_o   = 1'b0;
    illegal_o = 1'b0;
    if (valid_i) begin
      unique case (cmd_e'(cmd_i))
        CMD_ACT: begin
          if (open_i)                    illegal_o = 1'b1;
          else if (!(rp_ok_i && rc_ok_i)) stall_o  = 1'b1;
          else                           legal_o   = 1'b1;
        end
        CMD_RD, CMD_WR: begin
          if (!open_i)        illegal_o = 1'b1;
          else if (!rcd_ok_i) stall_o   = 1'b1;
          else                legal_o   = 1'b1;
        end
        CMD_PRE: legal_o = 1'b1;
        default: illegal_o = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker
  import bank_timing_pkg::*;
#(
  parameter int  NUM_BANKS = 8,
  parameter int  ROW_W     = 14,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int GW        = $clog2(NUM_GRADES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_valid_i,
  input  logic [1:0]                 cmd_i,
  input  logic [BANK_W-1:0]          bank_i,
  input  logic [ROW_W-1:0]           row_i,
  input  logic [GW-1:0]              grade_i,
  output logic                       cmd_legal_o,
  output logic                       cmd_stall_o,
  output logic                       cmd_illegal_o,
  output logic [NUM_BANKS-1:0]       bank_open_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o
);

  logic [CNT_W-1:0]     trcd, trp, trc;
  logic [NUM_BANKS-1:0] rcd_ok, rp_ok, rc_ok, act_sel, pre_sel;
  logic                 is_act, is_pre;

  grade_lut #(.GRADES(NUM_GRADES)) u_lut (
    .grade_i (grade_i),
    .trcd_o  (trcd),
    .trp_o   (trp),
    .trc_o   (trc)
  );

  cmd_judge u_judge (
    .valid_i   (cmd_valid_i),
    .cmd_i     (cmd_i),
    .open_i    (bank_open_o[bank_i]),
    .rcd_ok_i  (rcd_ok[bank_i]),
    .rp_ok_i   (rp_ok[bank_i]),
    .rc_ok_i   (rc_ok[bank_i]),
    .legal_o   (cmd_legal_o),
    .stall_o   (cmd_stall_o),
    .illegal_o (cmd_illegal_o)
  );

  assign is_act = cmd_legal_o && (cmd_e'(cmd_i) == CMD_ACT);
  assign is_pre = cmd_legal_o && (cmd_e'(cmd_i) == CMD_PRE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign act_sel[b] = is_act && (bank_i == BANK_W'(b));
    assign pre_sel[b] = is_pre && (bank_i == BANK_W'(b));

    bank_timer #(.ROW_W(ROW_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (act_sel[b]),
      .pre_i    (pre_sel[b]),
      .row_i    (row_i),
      .trcd_i   (trcd),
      .trp_i    (trp),
      .trc_i    (trc),
      .open_o   (bank_open_o[b]),
      .row_o    (open_row_o[b*ROW_W +: ROW_W]),
      .rcd_ok_o (rcd_ok[b]),
      .rp_ok_o  (rp_ok[b]),
      .rc_ok_o  (rc_ok[b])
    );
  end

  a_r12_quiet_when_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |-> !cmd_legal_o && !cmd_stall_o && !cmd_illegal_o);
  a_r12_one_verdict : assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> $onehot({cmd_legal_o, cmd_stall_o, cmd_illegal_o}));
  a_r11_stall_no_change : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cmd_legal_o) |=> $stable(bank_open_o) && $stable(open_row_o));
  a_r9_one_bank_per_cmd : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_sel | pre_sel));

endmodule

// File: tb/bank_timing_tracker_tb.sv
module bank_timing_tracker_tb;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid = 1'b0;
  logic [1:0]   cmd = '0;
  logic [2:0]   bank = '0;
  logic [13:0]  row = '0;
  logic [1:0]   grade = '0;
  logic         legal, stall, illegal;
  logic [7:0]   open_mask;
  logic [111:0] rows;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_timing_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(valid), .cmd_i(cmd),
    .bank_i(bank), .row_i(row), .grade_i(grade),
    .cmd_legal_o(legal), .cmd_stall_o(stall), .cmd_illegal_o(illegal),
    .bank_open_o(open_mask), .open_row_o(rows)
  );

  typedef struct packed {
    logic       v;
    logic [1:0] c;
    logic [2:0] b;
    logic [13:0] r;
    logic [2:0] flg;   // {legal, stall, illegal}
    logic [7:0] opn;   // open mask seen in this cycle
  } vec_t;

  // grade 0: tRCD = tRP = 3, tRC = 11
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 3'd0, 14'd5,  3'b100, 8'h00},  // ACT b0
    '{1'b1, 2'd1, 3'd0, 14'd0,  3'b010, 8'h01},  // RD inside tRCD
    '{1'b1, 2'd1, 3'd0, 14'd0,  3'b010, 8'h01},
    '{1'b1, 2'd1, 3'd0, 14'd0,  3'b100, 8'h01},  // RD at tRCD
    '{1'b1, 2'd0, 3'd0, 14'd99, 3'b001, 8'h01},  // ACT open bank
    '{1'b1, 2'd3, 3'd0, 14'd0,  3'b100, 8'h01},  // PRE b0
    '{1'b1, 2'd0, 3'd0, 14'd7,  3'b010, 8'h00},  // ACT inside tRP
    '{1'b1, 2'd2, 3'd1, 14'd0,  3'b001, 8'h00},  // WR closed bank
    '{1'b1, 2'd0, 3'd0, 14'd7,  3'b010, 8'h00},  // tRP met, tRC not
    '{1'b1, 2'd0, 3'd1, 14'd9,  3'b100, 8'h00},  // other bank free
    '{1'b1, 2'd0, 3'd0, 14'd7,  3'b010, 8'h02},
    '{1'b1, 2'd0, 3'd0, 14'd7,  3'b100, 8'h02},  // ACT at tRC
    '{1'b1, 2'd2, 3'd1, 14'd0,  3'b100, 8'h03},  // WR b1 at tRCD
    '{1'b1, 2'd3, 3'd3, 14'd0,  3'b100, 8'h03},  // PRE closed bank
    '{1'b1, 2'd0, 3'd3, 14'd3,  3'b100, 8'h03},  // no tRP started
    '{1'b0, 2'd0, 3'd2, 14'd0,  3'b000, 8'h0B}   // not valid
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] c, input logic [2:0] b,
                       input logic [13:0] r);
    @(negedge clk);
    valid = v; cmd = c; bank = b; row = r;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    valid = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  function automatic int cyc(int ns, int g);
    int mhz;
    mhz = (g == 0) ? 200 : (g == 1) ? 267 : (g == 2) ? 333 : 400;
    return (ns * mhz + 999) / 1000;
  endfunction

  // present c to b every cycle from cycle 'first' until legal; return that cycle
  task automatic scan(input logic [1:0] c, input logic [2:0] b, input int first,
                      output int n);
    n = -1;
    for (int k = first; k < 60; k++) begin
      drive(1'b1, c, b, 14'd1);
      if (legal) begin
        n = k;
        break;
      end
    end
    drive(1'b0, 2'd0, 3'd0, 14'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();

    // R1 reset state
    check(open_mask == 8'h00, "R1 open mask", open_mask, 0);
    check(rows == '0, "R1 rows zero", int'(rows[31:0]), 0);
    @(negedge clk);
    valid = 1'b1; cmd = 2'd1; bank = 3'd6; #1;
    check(illegal, "R1 read after reset illegal", illegal, 1);
    cmd = 2'd0; #1;
    check(legal, "R1 activate after reset legal", legal, 1);
    valid = 1'b0;

    // vector walk: R3 R4 R5 R6 R7 R9 R10 R11 R12
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].v, VECS[i].c, VECS[i].b, VECS[i].r);
      check({legal, stall, illegal} == VECS[i].flg,
            $sformatf("R5/R6/R7/R3/R4/R9/R10/R12 vec%0d flags", i),
            {legal, stall, illegal}, VECS[i].flg);
      check(open_mask == VECS[i].opn,
            $sformatf("R2/R3/R11 vec%0d open mask", i), open_mask, VECS[i].opn);
    end

    // R2 stored rows
    check(rows[0*14 +: 14] == 14'd7, "R2 row bank0", rows[0*14 +: 14], 7);
    check(rows[1*14 +: 14] == 14'd9, "R2 row bank1", rows[1*14 +: 14], 9);
    check(rows[3*14 +: 14] == 14'd3, "R2 row bank3", rows[3*14 +: 14], 3);

    // R4 illegal ACT keeps row
    drive(1'b1, 2'd0, 3'd1, 14'd77);
    check(illegal, "R4 act to open bank illegal", illegal, 1);
    drive(1'b0, 2'd0, 3'd0, 14'd0);
    check(rows[1*14 +: 14] == 14'd9, "R4 row unchanged", rows[1*14 +: 14], 9);

    // R8 with R5 R6 R7 per grade
    for (int g = 0; g < 4; g++) begin
      do_reset();
      grade = 2'(g);
      drive(1'b1, 2'd0, 3'd2, 14'd11);
      scan(2'd1, 3'd2, 1, n);
      check(n == cyc(15, g), $sformatf("R8 R5 tRCD grade%0d", g), n, cyc(15, g));

      do_reset();
      drive(1'b1, 2'd0, 3'd4, 14'd12);
      repeat (30) drive(1'b0, 2'd0, 3'd0, 14'd0);
      drive(1'b1, 2'd3, 3'd4, 14'd0);
      scan(2'd0, 3'd4, 1, n);
      check(n == cyc(15, g), $sformatf("R8 R6 tRP grade%0d", g), n, cyc(15, g));

      do_reset();
      drive(1'b1, 2'd0, 3'd5, 14'd13);
      drive(1'b1, 2'd3, 3'd5, 14'd0);
      scan(2'd0, 3'd5, 2, n);
      check(n == cyc((g == 0) ? 55 : 60, g), $sformatf("R8 R7 tRC grade%0d", g),
            n, cyc((g == 0) ? 55 : 60, g));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule